// File: doc/BRIEF.md
# Universal Hall Commutation Decoder

This block turns the three Hall sensor levels of a three-phase brushless motor into the drive state of its three half-bridge legs. Each leg is floating, tied to the supply through its high-side switch, or tied to ground through its low-side switch. One eight-entry table covers both the 60° and the 120° sensor spacing, because the codes used by only one spacing never appear with the other. Running the reverse direction also covers the 240° and 300° spacings, whose code sequences are the 120° and 60° sequences played backwards. No pin selects the sensor convention.

A small mode state machine sits in front of the table. It has three named states: `MODE_OFF` (all switches open), `MODE_BRAKE` (all three high-side switches closed) and `MODE_RUN` (table decode). Its transitions are `to_off` (taken from any state while the enable input is low), `to_brake` (taken from `MODE_OFF` or `MODE_RUN` while enable is high and the brake input is low) and `to_run` (taken from `MODE_OFF` or `MODE_BRAKE` while enable and brake are both high). Hall inputs pass through a two-flop synchronizer. The drive state and a one-hot sink flag are registered. The sink flag tells a current chopper which leg is currently returning current to ground.

Top module: `hall_commutator`

## Requirements
- R1: After reset every leg code is 00 (floating) and the sink flag is 000. Leg codes are 00 = floating, 01 = high side on (supply) and 10 = low side on (ground). `drive_o[1:0]` is OUT1, `[3:2]` is OUT2 and `[5:4]` is OUT3. The Hall code is written H1H2H3 with H1 = `hall_a`.
- R2: When running forward (`fwd` = 1), the codes map as follows. 100 gives OUT1 supply, OUT2 floating, OUT3 ground. 110 gives OUT1 floating, OUT2 supply, OUT3 ground. 011 gives OUT1 ground, OUT2 floating, OUT3 supply. 001 gives OUT1 floating, OUT2 ground, OUT3 supply.
- R3: When running forward, 010 and 111 both give OUT1 ground, OUT2 supply, OUT3 floating. 101 and 000 both give OUT1 supply, OUT2 ground, OUT3 floating.
- R4: When running in reverse (`fwd` = 0), every leg that would be at supply goes to ground and every leg that would be at ground goes to supply. Floating legs stay floating.
- R5: With enable high and `brake_n` low, all three leg codes are 01 and the sink flag is 000, whatever the Hall code.
- R6: With `drv_en` low, all leg codes are 00 and the sink flag is 000, even while `brake_n` is low.
- R7: A Hall change reaches the outputs on the third rising clock edge after it is applied. A change of `drv_en` or `brake_n` reaches them on the second edge. A change of `fwd` reaches them on the first edge.
- R8: `sink_o[k]` is 1 exactly when leg k is driven to ground. At most one bit is set.
- R9: No leg ever shows code 11. In run mode exactly two legs are active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_a | input | 1 | Hall sensor 1 (H1) |
| hall_b | input | 1 | Hall sensor 2 (H2) |
| hall_c | input | 1 | Hall sensor 3 (H3) |
| fwd | input | 1 | 1 = forward, 0 = reverse |
| brake_n | input | 1 | Low closes all high-side switches |
| drv_en | input | 1 | Low opens all switches |
| drive_o | output | 6 | Two-bit leg codes, OUT1 in the low bits |
| sink_o | output | 3 | One-hot flag of the leg tied to ground |

## Verification
A Hall code is due at the outputs on the third rising edge after it is applied: two synchronizer stages, then the output register. Enable and brake are due on the second edge, after the mode register and the output register. Direction is due on the first edge. The table walk applies each vector on a falling edge, waits three rising edges and samples on the next falling edge. Directed latency tests sample one edge before the due edge, to confirm the old value still holds, and again after it, so an extra or missing register stage is caught.

// File: rtl/hall_pkg.sv
package hall_pkg;

    // Leg drive code: bit 0 closes the high side, bit 1 closes the low side.
    typedef enum logic [1:0] {
        LEG_FLOAT = 2'b00,
        LEG_HIGH  = 2'b01,
        LEG_LOW   = 2'b10
    } leg_t;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_BRAKE = 2'b01,
        MODE_RUN   = 2'b10
    } mode_t;

    localparam int unsigned NUM_LEGS = 3;

    function automatic leg_t leg_swap(input leg_t l);
        unique case (l)
            LEG_HIGH: return LEG_LOW;
            LEG_LOW:  return LEG_HIGH;
            default:  return LEG_FLOAT;
        endcase
    endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/drive_mode_fsm.sv
module drive_mode_fsm
    import hall_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  drv_en,
    input  logic  brake_n,
    output mode_t mode_o,
    output logic  is_off,
    output logic  is_brake,
    output logic  is_run
);

    mode_t state_q, state_d;

    // Next state: enable outranks brake, brake outranks running.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OFF: begin
                if (drv_en && !brake_n)     state_d = MODE_BRAKE;  // to_brake
                else if (drv_en)            state_d = MODE_RUN;    // to_run
            end
            MODE_BRAKE: begin
                if (!drv_en)                state_d = MODE_OFF;    // to_off
                else if (brake_n)           state_d = MODE_RUN;    // to_run
            end
            MODE_RUN: begin
                if (!drv_en)                state_d = MODE_OFF;    // to_off
                else if (!brake_n)          state_d = MODE_BRAKE;  // to_brake
            end
            default:                        state_d = MODE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        is_off   = 1'b0;
        is_brake = 1'b0;
        is_run   = 1'b0;
        unique case (state_q)
            MODE_BRAKE: is_brake = 1'b1;
            MODE_RUN:   is_run   = 1'b1;
            default:    is_off   = 1'b1;
        endcase
    end

    assign mode_o = state_q;

    p_enable_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (state_q == MODE_OFF));

    p_brake_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !brake_n) |=> (state_q == MODE_BRAKE));

    p_one_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_off, is_brake, is_run}) == 1);

endmodule

// File: rtl/hall_decode.sv
module hall_decode
    import hall_pkg::*;
(
    input  logic [2:0] code_i,   // {H1, H2, H3}
    input  logic       fwd_i,
    output leg_t       leg_o [NUM_LEGS]
);

    leg_t fwd_leg [NUM_LEGS];

    // Forward table; 111 and 000 fill the gaps left by the other spacing.
    always_comb begin
        unique case (code_i)
            3'b100: begin fwd_leg[0] = LEG_HIGH;  fwd_leg[1] = LEG_FLOAT; fwd_leg[2] = LEG_LOW;   end
            3'b110: begin fwd_leg[0] = LEG_FLOAT; fwd_leg[1] = LEG_HIGH;  fwd_leg[2] = LEG_LOW;   end
            3'b010,
            3'b111: begin fwd_leg[0] = LEG_LOW;   fwd_leg[1] = LEG_HIGH;  fwd_leg[2] = LEG_FLOAT; end
            3'b011: begin fwd_leg[0] = LEG_LOW;   fwd_leg[1] = LEG_FLOAT; fwd_leg[2] = LEG_HIGH;  end
            3'b001: begin fwd_leg[0] = LEG_FLOAT; fwd_leg[1] = LEG_LOW;   fwd_leg[2] = LEG_HIGH;  end
            default: begin fwd_leg[0] = LEG_HIGH; fwd_leg[1] = LEG_LOW;   fwd_leg[2] = LEG_FLOAT; end
        endcase
    end

    generate
        for (genvar k = 0; k < NUM_LEGS; k++) begin : g_dir
            assign leg_o[k] = fwd_i ? fwd_leg[k] : leg_swap(fwd_leg[k]);
        end
    endgenerate

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hall_a,
    input  logic       hall_b,
    input  logic       hall_c,
    input  logic       fwd,
    input  logic       brake_n,
    input  logic       drv_en,
    output logic [5:0] drive_o,
    output logic [2:0] sink_o
);

    localparam int unsigned DRV_W = 2 * NUM_LEGS;

    logic [2:0]       hall_s;
    mode_t            mode;
    logic             is_off, is_brake, is_run;
    leg_t             dec_leg [NUM_LEGS];
    logic [DRV_W-1:0] drive_d, drive_q;
    logic [NUM_LEGS-1:0] sink_d, sink_q, active;

    hall_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hall_a, hall_b, hall_c}),
        .sync_o  (hall_s)
    );

    drive_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_en   (drv_en),
        .brake_n  (brake_n),
        .mode_o   (mode),
        .is_off   (is_off),
        .is_brake (is_brake),
        .is_run   (is_run)
    );

    hall_decode u_dec (
        .code_i (hall_s),
        .fwd_i  (fwd),
        .leg_o  (dec_leg)
    );

    generate
        for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
            always_comb begin
                unique case (mode)
                    MODE_RUN:   drive_d[2*k +: 2] = dec_leg[k];
                    MODE_BRAKE: drive_d[2*k +: 2] = LEG_HIGH;
                    default:    drive_d[2*k +: 2] = LEG_FLOAT;
                endcase
                sink_d[k] = (mode == MODE_RUN) && (dec_leg[k] == LEG_LOW);
            end
            assign active[k] = |drive_q[2*k +: 2];

            p_no_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
                drive_q[2*k +: 2] != 2'b11);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
            sink_q  <= '0;
        end else begin
            drive_q <= drive_d;
            sink_q  <= sink_d;
        end
    end

    assign drive_o = drive_q;
    assign sink_o  = sink_q;

    p_off_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_off |=> (drive_o == '0 && sink_o == '0));

    p_brake_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_brake |=> (drive_o == 6'b010101 && sink_o == '0));

    p_two_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_run |=> ($countones(active) == 2));

    p_sink_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sink_o));

endmodule

// File: tb/sim_hall_commutator.sv
module sim_hall_commutator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hall_a = 1'b0, hall_b = 1'b0, hall_c = 1'b0;
    logic       fwd = 1'b1, brake_n = 1'b1, drv_en = 1'b0;
    logic [5:0] drive_o;
    logic [2:0] sink_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hall_commutator u0 (
        .clk(clk), .rst_n(rst_n),
        .hall_a(hall_a), .hall_b(hall_b), .hall_c(hall_c),
        .fwd(fwd), .brake_n(brake_n), .drv_en(drv_en),
        .drive_o(drive_o), .sink_o(sink_o)
    );

    // {fwd, H1H2H3, expected {OUT3,OUT2,OUT1}}: 00 float, 01 supply, 10 ground
    localparam logic [9:0] VEC [16] = '{
        {1'b1, 3'b100, 6'b100001}, {1'b1, 3'b110, 6'b100100},
        {1'b1, 3'b010, 6'b000110}, {1'b1, 3'b011, 6'b010010},
        {1'b1, 3'b001, 6'b011000}, {1'b1, 3'b101, 6'b001001},
        {1'b1, 3'b111, 6'b000110}, {1'b1, 3'b000, 6'b001001},
        {1'b0, 3'b100, 6'b010010}, {1'b0, 3'b110, 6'b011000},
        {1'b0, 3'b010, 6'b001001}, {1'b0, 3'b011, 6'b100001},
        {1'b0, 3'b001, 6'b100100}, {1'b0, 3'b101, 6'b000110},
        {1'b0, 3'b111, 6'b001001}, {1'b0, 3'b000, 6'b000110}
    };

    function automatic logic [2:0] sink_of(input logic [5:0] d);
        for (int k = 0; k < 3; k++) sink_of[k] = (d[2*k +: 2] == 2'b10);
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got drive=%b sink=%b, expected drive=%b sink=%b",
                     req, act[8:3], act[2:0], exp[8:3], exp[2:0]);
        end
    endtask

    task automatic set_hall(input logic [2:0] c);
        hall_a = c[2]; hall_b = c[1]; hall_c = c[0];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {drive_o, sink_o}, 9'b0);
        rst_n = 1'b1;
        drv_en = 1'b1;
        repeat (4) @(posedge clk);

        // Table walk: R2 R3 (forward), R4 (reverse), R8 sink, R9 legality
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            fwd = VEC[i][9];
            set_hall(VEC[i][8:6]);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(VEC[i][9] ? (i == 6 || i == 7 ? "R3 fwd" : "R2 fwd") : "R4 rev",
                  {drive_o, sink_o}, {VEC[i][5:0], sink_of(VEC[i][5:0])});
        end

        // R7 Hall latency: old value after two edges, new after three
        @(negedge clk); fwd = 1'b1; set_hall(3'b100);
        repeat (3) @(posedge clk); @(negedge clk);
        set_hall(3'b011);
        repeat (2) @(posedge clk); @(negedge clk);
        check("R7 hall not yet", {drive_o, sink_o}, {6'b100001, 3'b100});
        @(posedge clk); @(negedge clk);
        check("R7 hall due", {drive_o, sink_o}, {6'b010010, 3'b001});

        // R7 direction latency: one edge
        fwd = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 dir due", {drive_o, sink_o}, {6'b100001, 3'b100});

        // R5 brake overrides decode; R7 two-edge latency
        brake_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 brake not yet", {drive_o, sink_o}, {6'b100001, 3'b100});
        @(posedge clk); @(negedge clk);
        check("R5 brake", {drive_o, sink_o}, {6'b010101, 3'b000});
        set_hall(3'b110);
        repeat (3) @(posedge clk); @(negedge clk);
        check("R5 brake ignores hall", {drive_o, sink_o}, {6'b010101, 3'b000});

        // R6 enable low overrides brake
        drv_en = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        check("R6 off over brake", {drive_o, sink_o}, 9'b0);
        brake_n = 1'b1;
        set_hall(3'b001);
        repeat (3) @(posedge clk); @(negedge clk);
        check("R6 off ignores hall", {drive_o, sink_o}, 9'b0);

        // Leaving off: reverse 001 -> OUT1 float, OUT2 supply, OUT3 ground
        drv_en = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7 enable not yet", {drive_o, sink_o}, 9'b0);
        @(posedge clk); @(negedge clk);
        check("R4 R8 resume", {drive_o, sink_o}, {6'b100100, 3'b100});

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 async reset", {drive_o, sink_o}, 9'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule